// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Overflow Flag

A purely combinational integer arithmetic-logic unit for the execute stage of a small RISC pipeline. It receives an operation code, a first operand, a second register operand and a short immediate. A select input makes the immediate the second operand. It returns a result word and a single overflow flag, which is the only exception indication the unit produces.

Add, subtract and negate each come in two forms. The flagging form raises overflow on two's-complement overflow. The plain form produces the same result bits and never flags. The unit also covers the four two-input bitwise operations, bitwise NOT, three shifts, two rotates and absolute value. Register-file access, decoding and exception handling are left to the surrounding core. Data width and immediate width are parameters, with defaults of 32 and 16 bits.

Top module: `int_alu`

## Requirements
- R1: Code 0 adds and code 2 subtracts (a minus the second operand), modulo 2^W. Each raises `ovf_o` on signed overflow: for add, the operands share a sign and the result sign differs from it; for subtract, the operand signs differ and the result sign differs from that of `a_i`.
- R2: Codes 1 (add), 3 (subtract) and 15 (negate) give the same result bits as their flagging counterparts (codes 0, 2 and 14) and never raise `ovf_o`.
- R3: Code 4 gives AND, 5 gives OR, 6 gives XOR and 7 gives NOR of `a_i` and the second operand. Code 16 gives the bitwise inverse of `a_i`. None of these raises `ovf_o`.
- R4: When `use_imm_i` is 1, the immediate replaces `b_i`. It is sign-extended for codes 0 to 3 and zero-extended for every other code.
- R5: Code 8 shifts left logical, 9 shifts right logical and 10 shifts right arithmetic. Only the low log2(W) bits of the second operand set the distance, and `ovf_o` stays 0.
- R6: Code 11 rotates `a_i` left and code 12 rotates it right, with the distance taken the same way as for shifts. The number of one bits is preserved, and `ovf_o` stays 0.
- R7: Code 13 returns the magnitude of `a_i` as a signed value. For the most negative value it returns the operand unchanged and raises `ovf_o`.
- R8: Code 14 returns zero minus `a_i`, and raises `ovf_o` only when `a_i` is the most negative value.
- R9: Codes 17 to 31 return a zero result with `ovf_o` at 0. The unary codes (13, 14, 15, 16) ignore the second operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second register operand |
| imm_i | input | IMMW | Immediate field |
| use_imm_i | input | 1 | Use the immediate as the second operand |
| res_o | output | W | Result |
| ovf_o | output | 1 | Signed overflow |

## Verification
An 8-bit unit with a 4-bit immediate is swept over every first operand. For each one it is driven with a stride of second operands, in both register and immediate form, under every operation code. Each result is compared with arithmetic done on signed and unsigned integers, so sign boundaries, shift distances wider than the word and immediates with their top bit set are all exercised. The default 32-bit instance is driven with directed corners: sums that cross the most positive value, the most negative value under absolute value and both negates, and a shift distance above 31. These corners separate the flagging forms from the plain ones and show that only the low distance bits are used.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W    = 32,
  parameter int IMMW = 16
) (
  input  logic [4:0]      op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            use_imm_i,
  output logic [W-1:0]    res_o,
  output logic            ovf_o
);
  localparam int SHW = $clog2(W);

  typedef enum logic [4:0] {
    OP_ADD = 5'd0, OP_ADDU = 5'd1, OP_SUB = 5'd2, OP_SUBU = 5'd3,
    OP_AND = 5'd4, OP_OR = 5'd5, OP_XOR = 5'd6, OP_NOR = 5'd7,
    OP_SLL = 5'd8, OP_SRL = 5'd9, OP_SRA = 5'd10, OP_ROL = 5'd11,
    OP_ROR = 5'd12, OP_ABS = 5'd13, OP_NEG = 5'd14, OP_NEGU = 5'd15,
    OP_NOT = 5'd16
  } op_e;

  logic            is_arith;
  logic [W-1:0]    imm_s, imm_z, opb;
  logic [W-1:0]    add_r, sub_r, neg_r;
  logic [SHW-1:0]  sh;
  logic [2*W-1:0]  rot_l, rot_r;
  logic            add_v, sub_v, a_min;
  logic [W-1:0]    res_c;
  logic            ovf_c;

  assign is_arith = (op_i <= OP_SUBU);
  assign imm_s    = {{(W-IMMW){imm_i[IMMW-1]}}, imm_i};
  assign imm_z    = {{(W-IMMW){1'b0}}, imm_i};
  assign opb      = !use_imm_i ? b_i : (is_arith ? imm_s : imm_z);

  assign add_r = a_i + opb;
  assign sub_r = a_i - opb;
  assign neg_r = '0 - a_i;
  assign sh    = opb[SHW-1:0];
  assign rot_l = {a_i, a_i} << sh;
  assign rot_r = {a_i, a_i} >> sh;

  assign add_v = (a_i[W-1] == opb[W-1]) && (add_r[W-1] != a_i[W-1]);
  assign sub_v = (a_i[W-1] != opb[W-1]) && (sub_r[W-1] != a_i[W-1]);
  assign a_min = a_i[W-1] && !(|a_i[W-2:0]);

  always_comb begin
    res_c = '0;
    ovf_c = 1'b0;
    case (op_e'(op_i))
      OP_ADD:  begin res_c = add_r; ovf_c = add_v; end
      OP_ADDU: res_c = add_r;
      OP_SUB:  begin res_c = sub_r; ovf_c = sub_v; end
      OP_SUBU: res_c = sub_r;
      OP_AND:  res_c = a_i & opb;
      OP_OR:   res_c = a_i | opb;
      OP_XOR:  res_c = a_i ^ opb;
      OP_NOR:  res_c = ~(a_i | opb);
      OP_SLL:  res_c = a_i << sh;
      OP_SRL:  res_c = a_i >> sh;
      OP_SRA:  res_c = $signed(a_i) >>> sh;
      OP_ROL:  res_c = rot_l[2*W-1:W];
      OP_ROR:  res_c = rot_r[W-1:0];
      OP_ABS:  begin res_c = a_i[W-1] ? neg_r : a_i; ovf_c = a_min; end
      OP_NEG:  begin res_c = neg_r; ovf_c = a_min; end
      OP_NEGU: res_c = neg_r;
      OP_NOT:  res_c = ~a_i;
      default: ;
    endcase

    if (!$isunknown({op_i, a_i, b_i, imm_i, use_imm_i})) begin
      AST_UNSIGNED_NO_OVF: assert (!((op_i == OP_ADDU || op_i == OP_SUBU || op_i == OP_NEGU) && ovf_c)); // R2
      AST_LOGIC_NO_OVF: assert (!((op_i >= OP_AND && op_i <= OP_ROR || op_i == OP_NOT) && ovf_c)); // R3
      AST_ROTATE_ONES: assert (!(op_i == OP_ROL || op_i == OP_ROR) || $countones(res_c) == $countones(a_i)); // R6
      AST_ABS_SIGN: assert (op_i != OP_ABS || !res_c[W-1] || ovf_c); // R7
      AST_NOT_ONES: assert (op_i != OP_NOT || $countones(res_c) + $countones(a_i) == W); // R3
    end

    res_o = res_c;
    ovf_o = ovf_c;
  end
endmodule

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;
  typedef longint unsigned u64_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [4:0]  op32, op8;
  logic [31:0] a32, b32, r32;
  logic [15:0] imm32;
  logic [7:0]  a8, b8, r8;
  logic [3:0]  imm8;
  logic        ui32, ui8, v32, v8;

  int_alu #(.W(32), .IMMW(16)) dut (
    .op_i(op32), .a_i(a32), .b_i(b32), .imm_i(imm32), .use_imm_i(ui32),
    .res_o(r32), .ovf_o(v32));

  int_alu #(.W(8), .IMMW(4)) dut8 (
    .op_i(op8), .a_i(a8), .b_i(b8), .imm_i(imm8), .use_imm_i(ui8),
    .res_o(r8), .ovf_o(v8));

  function automatic logic [32:0] model(input int op, input u64_t a_in, input u64_t b_in,
                                        input u64_t imm, input bit ui, input int w, input int iw);
    u64_t m, a, bv, r;
    longint as, bs, s, mn, mx;
    int sh;
    bit o;
    m  = (u64_t'(1) << w) - 1;
    mn = -(longint'(1) << (w - 1));
    mx = (longint'(1) << (w - 1)) - 1;
    a  = a_in & m;
    if (ui) begin
      bv = imm & ((u64_t'(1) << iw) - 1);
      if (op <= 3 && bv[iw-1]) bv = bv | (m & ~((u64_t'(1) << iw) - 1));
    end else bv = b_in & m;
    as = a[w-1]  ? longint'(a)  - longint'(u64_t'(1) << w) : longint'(a);
    bs = bv[w-1] ? longint'(bv) - longint'(u64_t'(1) << w) : longint'(bv);
    sh = int'(bv % u64_t'(w));
    o = 1'b0;
    r = 0;
    case (op)
      0, 1: begin s = as + bs; r = u64_t'(s) & m; o = (op == 0) && (s > mx || s < mn); end
      2, 3: begin s = as - bs; r = u64_t'(s) & m; o = (op == 2) && (s > mx || s < mn); end
      4: r = a & bv;
      5: r = a | bv;
      6: r = a ^ bv;
      7: r = ~(a | bv) & m;
      8: r = (a << sh) & m;
      9: r = a >> sh;
      10: r = u64_t'(as >>> sh) & m;
      11: r = ((a << sh) | (a >> (w - sh))) & m;
      12: r = ((a >> sh) | (a << (w - sh))) & m;
      13: begin r = (as < 0) ? (u64_t'(-as) & m) : a; o = (as == mn); end
      14, 15: begin r = u64_t'(-as) & m; o = (op == 14) && (as == mn); end
      16: r = ~a & m;
      default: r = 0;
    endcase
    return {o, r[31:0]};
  endfunction

  function automatic string tag(input int op, input bit ui);
    if (ui && op <= 7) return "R4";
    case (op)
      0, 2: return "R1";
      1, 3, 15: return "R2";
      4, 5, 6, 7, 16: return "R3";
      8, 9, 10: return "R5";
      11, 12: return "R6";
      13: return "R7";
      14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk32(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input bit ui, input string rq);
    logic [32:0] e;
    op32 = 5'(op); a32 = a; b32 = b; imm32 = imm; ui32 = ui;
    #1;
    e = model(op, u64_t'(a), u64_t'(b), u64_t'(imm), ui, 32, 16);
    checks++;
    if (r32 !== e[31:0] || v32 !== e[32]) begin
      errors++;
      $display("FAIL %s w32 op=%0d a=%h b=%h imm=%h ui=%0d: got res=%h ovf=%0b expected res=%h ovf=%0b",
               rq, op, a, b, imm, ui, r32, v32, e[31:0], e[32]);
    end
  endtask

  task automatic chk8(input int op, input logic [7:0] a, input logic [7:0] b,
                      input logic [3:0] imm, input bit ui);
    logic [32:0] e;
    op8 = 5'(op); a8 = a; b8 = b; imm8 = imm; ui8 = ui;
    #1;
    e = model(op, u64_t'(a), u64_t'(b), u64_t'(imm), ui, 8, 4);
    checks++;
    if (r8 !== e[7:0] || v8 !== e[32]) begin
      errors++;
      $display("FAIL %s w8 op=%0d a=%h b=%h imm=%h ui=%0d: got res=%h ovf=%0b expected res=%h ovf=%0b",
               tag(op, ui), op, a, b, imm, ui, r8, v8, e[7:0], e[32]);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    op32 = 0; a32 = 0; b32 = 0; imm32 = 0; ui32 = 0;
    op8 = 0; a8 = 0; b8 = 0; imm8 = 0; ui8 = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (r32 !== 32'h0 || v32 !== 1'b0 || r8 !== 8'h0 || v8 !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got res=%h ovf=%0b expected res=0 ovf=0", r32, v32);
    end

    chk32(0, 32'h7fffffff, 32'h1, 16'h0, 0, "R1");
    chk32(1, 32'h7fffffff, 32'h1, 16'h0, 0, "R2");
    chk32(2, 32'h80000000, 32'h1, 16'h0, 0, "R1");
    chk32(3, 32'h80000000, 32'h1, 16'h0, 0, "R2");
    chk32(0, 32'h80000000, 32'h80000000, 16'h0, 0, "R1");
    chk32(0, 32'h5, 32'h0, 16'hffff, 1, "R4");
    chk32(4, 32'hffffffff, 32'h0, 16'h8000, 1, "R4");
    chk32(7, 32'h0f0f0f0f, 32'h00ff00ff, 16'h0, 0, "R3");
    chk32(16, 32'h12345678, 32'h0, 16'h0, 0, "R3");
    chk32(8, 32'h1, 32'd33, 16'h0, 0, "R5");
    chk32(10, 32'h80000000, 32'd31, 16'h0, 0, "R5");
    chk32(11, 32'h80000001, 32'd4, 16'h0, 0, "R6");
    chk32(12, 32'h80000001, 32'h0, 16'd36, 1, "R6");
    chk32(13, 32'h80000000, 32'h0, 16'h0, 0, "R7");
    chk32(13, 32'hfffffffb, 32'h0, 16'h0, 0, "R7");
    chk32(14, 32'h80000000, 32'h0, 16'h0, 0, "R8");
    chk32(15, 32'h80000000, 32'h0, 16'h0, 0, "R2");
    chk32(14, 32'h7, 32'h0, 16'h0, 0, "R8");
    chk32(20, 32'hffffffff, 32'hffffffff, 16'hffff, 0, "R9");

    for (int op = 0; op < 32; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += (op > 16 ? 61 : 7)) begin
          chk8(op, 8'(a), 8'(b), 4'(b), 1'b0);
          chk8(op, 8'(a), 8'(~b), 4'(b), 1'b1);
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end
endmodule